// File: doc/BRIEF.md
# DMA Chain Descriptor Register Loader

This block holds the per-channel address registers of a DMA engine that walks a linked chain of descriptors in memory. A descriptor reader returns the dwords of each fetched descriptor one at a time, each tagged with its index. The block drops every dword into the register that matches that index. When the last dword of a descriptor has arrived, the block checks the next-descriptor pointer. If the pointer is nonzero, it asks for the next descriptor. If both halves of the pointer are zero, the chain has ended and the channel goes idle.

Software reaches the block through a small select-addressed port. Software can write the next-descriptor pointer halves and a control register that holds a Start bit, and it can read back every register and a status word. The pointer is locked against software writes while Start is set or the channel is active. A Start with an all-zero pointer launches nothing. The block also raises a sticky abort when the target type of a source read or destination write does not match the configured type. It raises a sticky alignment error when a pointer is used that is not on a 32-byte boundary.

The state machine has four states:
- ST_IDLE: the channel is not active.
- ST_ISSUE: the block drives a one-cycle fetch request.
- ST_LOAD: the block accepts descriptor dwords.
- ST_CHECK: the block decides whether the chain goes on.

Its transitions are:
- launch: ST_IDLE to ST_ISSUE, when Start is written to 1 and the pointer is nonzero.
- issue done: ST_ISSUE to ST_LOAD.
- last dword: ST_LOAD to ST_CHECK.
- chain continues: ST_CHECK to ST_ISSUE.
- chain end: ST_CHECK to ST_IDLE.
- abort: any active state to ST_IDLE.

Top module: `dma_desc_loader`

## Requirements
- R1: After reset, every register read (select codes 0 to 7) returns zero, `fetch_req` is low and `chan_active` is low.
- R2: While the channel waits for descriptor data, a dword with index 0, 1, 2, 3, 4 or 5 loads source-low, source-high, destination-low, destination-high, pointer-low or pointer-high respectively. Read select codes 0 to 5 return these same registers. A dword that arrives while the channel is idle is ignored.
- R3: A software write to the pointer-low register (select 4) or pointer-high register (select 5) takes effect only while the Start bit and the active state are both clear. Otherwise the write is ignored. Select 6 writes the Start bit from data bit 0.
- R4: A write of Start=1 while idle with both pointer halves zero produces no fetch request and leaves the channel inactive.
- R5: A write of Start=1 while idle with a nonzero pointer sets `chan_active` in the next cycle. In that same cycle the block raises `fetch_req` for exactly one cycle, with `fetch_addr` set to the pointer with its low 5 bits forced to zero.
- R6: Two cycles after the index-5 dword is taken, the channel does one of two things. If either pointer half is nonzero, it issues a fetch for the new pointer. If both halves are zero, it goes inactive.
- R7: If the pointer used for a fetch has any of its low 5 bits set, status bit 1 (alignment error) is set. The bit stays set until the next launch.
- R8: While the channel is active, a source-read type that differs from `src_type_cfg`, or a destination-write type that differs from `dst_type_cfg`, has two effects in the next cycle: status bit 2 (abort) is set and the channel goes inactive. A launch clears both flags. Status bit 0 is the active state.
- R9: `src_addr` and `dst_addr` pass the low registers through at any byte alignment. With `WIDE_ADDR`=0 they are 32 bits wide and the upper registers do not reach them, though they are still loaded and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 3 | Software write register select |
| sw_wr_data | input | AW | Software write data |
| sw_rd_sel | input | 3 | Software read register select |
| sw_rd_data | output | AW | Software read data (combinational) |
| dsc_valid | input | 1 | Descriptor dword valid |
| dsc_idx | input | 3 | Descriptor dword index |
| dsc_data | input | AW | Descriptor dword value |
| fetch_req | output | 1 | One-cycle request to the descriptor reader |
| fetch_addr | output | AW or 2*AW | Descriptor address to fetch, 32-byte aligned |
| src_addr | output | AW or 2*AW | Current source address |
| dst_addr | output | AW or 2*AW | Current destination address |
| src_type_cfg | input | TW | Configured source target type |
| dst_type_cfg | input | TW | Configured destination target type |
| rd_chk_valid | input | 1 | A source read target type is reported |
| rd_chk_type | input | TW | Reported source read target type |
| wr_chk_valid | input | 1 | A destination write target type is reported |
| wr_chk_type | input | TW | Reported destination write target type |
| chan_active | output | 1 | Channel active |
| align_err | output | 1 | Sticky misaligned-pointer flag |
| xfer_abort | output | 1 | Sticky type-mismatch abort flag |

## Verification
The block has three delays that the checks depend on:
- A register write or descriptor dword taken at a clock edge is visible on the read port and address outputs immediately after that edge.
- A launch shows `fetch_req` and `chan_active` in the cycle right after the write edge. A final dword shows the follow-on fetch, or the drop of `chan_active`, two edges later.
- An abort shows in the status word one edge after the mismatch is driven.

The bench drives all inputs just after a falling edge and reads outputs at the following falling edges. A scoreboard queue holds the expected fetch addresses. A monitor compares each `fetch_req` against that queue at the falling edge where it is due, and it flags any fetch that was not expected.

// File: rtl/dma_dl_pkg.sv
package dma_dl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_LOAD  = 2'd2,
        ST_CHECK = 2'd3
    } dl_state_e;

    localparam logic [2:0] SEL_SRC_LO = 3'd0;
    localparam logic [2:0] SEL_SRC_HI = 3'd1;
    localparam logic [2:0] SEL_DST_LO = 3'd2;
    localparam logic [2:0] SEL_DST_HI = 3'd3;
    localparam logic [2:0] SEL_ND_LO  = 3'd4;
    localparam logic [2:0] SEL_ND_HI  = 3'd5;
    localparam logic [2:0] SEL_CTRL   = 3'd6;
    localparam logic [2:0] SEL_STAT   = 3'd7;

    localparam int unsigned DESC_DWORDS = 6;

endpackage

// File: rtl/dma_dl_regs.sv
module dma_dl_regs
    import dma_dl_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned NW = DESC_DWORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_wr_en,
    input  logic [2:0]         sw_wr_sel,
    input  logic [AW-1:0]      sw_wr_data,
    input  logic               nd_protect,
    input  logic               dsc_load,
    input  logic [2:0]         dsc_idx,
    input  logic [AW-1:0]      dsc_data,
    output logic [NW-1:0][AW-1:0] regs_q,
    output logic               start_q
);

    // One register per descriptor dword index; only the pointer halves
    // are reachable from software.
    for (genvar i = 0; i < NW; i++) begin : g_reg
        localparam logic [2:0] IDX = 3'(i);
        localparam bit SW_OK = (IDX == SEL_ND_LO) || (IDX == SEL_ND_HI);
        logic [AW-1:0] q;
        logic          sw_hit;
        logic          dsc_hit;

        assign sw_hit  = SW_OK && sw_wr_en && !nd_protect && (sw_wr_sel == IDX);
        assign dsc_hit = dsc_load && (dsc_idx == IDX);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (dsc_hit) q <= dsc_data;
            else if (sw_hit)  q <= sw_wr_data;
        end

        assign regs_q[i] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  start_q <= 1'b0;
        else if (sw_wr_en && sw_wr_sel == SEL_CTRL)  start_q <= sw_wr_data[0];
    end

endmodule

// File: rtl/dma_dl_fsm.sv
module dma_dl_fsm
    import dma_dl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch_go,
    input  logic      last_dword,
    input  logic      chain_zero,
    input  logic      abort_hit,
    output dl_state_e state_q,
    output logic      fetch_req,
    output logic      chan_active,
    output logic      launch
);

    dl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch_go)       state_d = ST_ISSUE;
            ST_ISSUE: if (abort_hit)       state_d = ST_IDLE;
                      else                 state_d = ST_LOAD;
            ST_LOAD:  if (abort_hit)       state_d = ST_IDLE;
                      else if (last_dword) state_d = ST_CHECK;
            ST_CHECK: if (abort_hit || chain_zero) state_d = ST_IDLE;
                      else                 state_d = ST_ISSUE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fetch_req   = (state_q == ST_ISSUE);
        chan_active = (state_q != ST_IDLE);
        launch      = (state_q == ST_IDLE) && launch_go;
    end

endmodule

// File: rtl/dma_dl_flags.sv
module dma_dl_flags #(
    parameter int unsigned TW = 2,
    parameter int unsigned AB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_active,
    input  logic          launch,
    input  logic          fetch_req,
    input  logic [AB-1:0] ptr_low_bits,
    input  logic [TW-1:0] src_type_cfg,
    input  logic [TW-1:0] dst_type_cfg,
    input  logic          rd_chk_valid,
    input  logic [TW-1:0] rd_chk_type,
    input  logic          wr_chk_valid,
    input  logic [TW-1:0] wr_chk_type,
    output logic          abort_hit,
    output logic          align_q,
    output logic          abort_q
);

    assign abort_hit = chan_active &&
                       ((rd_chk_valid && (rd_chk_type != src_type_cfg)) ||
                        (wr_chk_valid && (wr_chk_type != dst_type_cfg)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            align_q <= 1'b0;
            abort_q <= 1'b0;
        end else if (launch) begin
            align_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            if (fetch_req && (|ptr_low_bits)) align_q <= 1'b1;
            if (abort_hit)                    abort_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
    import dma_dl_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned TW        = 2,
    parameter int unsigned AB        = 5,
    parameter bit          WIDE_ADDR = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               sw_wr_en,
    input  logic [2:0]                         sw_wr_sel,
    input  logic [AW-1:0]                      sw_wr_data,
    input  logic [2:0]                         sw_rd_sel,
    output logic [AW-1:0]                      sw_rd_data,
    input  logic                               dsc_valid,
    input  logic [2:0]                         dsc_idx,
    input  logic [AW-1:0]                      dsc_data,
    output logic                               fetch_req,
    output logic [(WIDE_ADDR ? 2*AW : AW)-1:0] fetch_addr,
    output logic [(WIDE_ADDR ? 2*AW : AW)-1:0] src_addr,
    output logic [(WIDE_ADDR ? 2*AW : AW)-1:0] dst_addr,
    input  logic [TW-1:0]                      src_type_cfg,
    input  logic [TW-1:0]                      dst_type_cfg,
    input  logic                               rd_chk_valid,
    input  logic [TW-1:0]                      rd_chk_type,
    input  logic                               wr_chk_valid,
    input  logic [TW-1:0]                      wr_chk_type,
    output logic                               chan_active,
    output logic                               align_err,
    output logic                               xfer_abort
);

    localparam int unsigned NW   = DESC_DWORDS;
    localparam logic [2:0]  LAST = 3'(NW - 1);

    logic [NW-1:0][AW-1:0] regs_q;
    logic                  start_q;
    logic                  nd_protect;
    logic                  dsc_load;
    logic                  last_dword;
    logic                  chain_zero;
    logic                  launch_go;
    logic                  launch;
    logic                  abort_hit;
    dl_state_e             state_q;

    assign chain_zero = (regs_q[SEL_ND_LO] == '0) && (regs_q[SEL_ND_HI] == '0);
    assign nd_protect = start_q || chan_active;
    assign dsc_load   = dsc_valid && (state_q == ST_LOAD);
    assign last_dword = dsc_valid && (dsc_idx == LAST);
    assign launch_go  = sw_wr_en && (sw_wr_sel == SEL_CTRL) && sw_wr_data[0] && !chain_zero;

    dma_dl_regs #(.AW(AW), .NW(NW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_sel  (sw_wr_sel),
        .sw_wr_data (sw_wr_data),
        .nd_protect (nd_protect),
        .dsc_load   (dsc_load),
        .dsc_idx    (dsc_idx),
        .dsc_data   (dsc_data),
        .regs_q     (regs_q),
        .start_q    (start_q)
    );

    dma_dl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_go   (launch_go),
        .last_dword  (last_dword),
        .chain_zero  (chain_zero),
        .abort_hit   (abort_hit),
        .state_q     (state_q),
        .fetch_req   (fetch_req),
        .chan_active (chan_active),
        .launch      (launch)
    );

    dma_dl_flags #(.TW(TW), .AB(AB)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_active  (chan_active),
        .launch       (launch),
        .fetch_req    (fetch_req),
        .ptr_low_bits (regs_q[SEL_ND_LO][AB-1:0]),
        .src_type_cfg (src_type_cfg),
        .dst_type_cfg (dst_type_cfg),
        .rd_chk_valid (rd_chk_valid),
        .rd_chk_type  (rd_chk_type),
        .wr_chk_valid (wr_chk_valid),
        .wr_chk_type  (wr_chk_type),
        .abort_hit    (abort_hit),
        .align_q      (align_err),
        .abort_q      (xfer_abort)
    );

    // Address width variant: upper halves reach the outputs only when wide.
    if (WIDE_ADDR) begin : g_wide
        assign src_addr   = {regs_q[SEL_SRC_HI], regs_q[SEL_SRC_LO]};
        assign dst_addr   = {regs_q[SEL_DST_HI], regs_q[SEL_DST_LO]};
        assign fetch_addr = {regs_q[SEL_ND_HI], regs_q[SEL_ND_LO][AW-1:AB], {AB{1'b0}}};
    end else begin : g_narrow
        assign src_addr   = regs_q[SEL_SRC_LO];
        assign dst_addr   = regs_q[SEL_DST_LO];
        assign fetch_addr = {regs_q[SEL_ND_LO][AW-1:AB], {AB{1'b0}}};
    end

    always_comb begin
        unique case (sw_rd_sel)
            SEL_SRC_LO: sw_rd_data = regs_q[0];
            SEL_SRC_HI: sw_rd_data = regs_q[1];
            SEL_DST_LO: sw_rd_data = regs_q[2];
            SEL_DST_HI: sw_rd_data = regs_q[3];
            SEL_ND_LO:  sw_rd_data = regs_q[4];
            SEL_ND_HI:  sw_rd_data = regs_q[5];
            SEL_CTRL:   sw_rd_data = {{(AW-1){1'b0}}, start_q};
            default:    sw_rd_data = {{(AW-3){1'b0}}, xfer_abort, align_err, chan_active};
        endcase
    end

endmodule

// File: rtl/dma_dl_checker.sv
module dma_dl_checker
    import dma_dl_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned AB = 5
) (
    input logic          clk,
    input logic          rst_n,
    input dl_state_e     state_q,
    input logic          chan_active,
    input logic          fetch_req,
    input logic [AB-1:0] fetch_low,
    input logic [AW-1:0] nd_lo,
    input logic [AW-1:0] nd_hi,
    input logic          nd_protect,
    input logic          dsc_load,
    input logic          chain_zero,
    input logic          abort_hit,
    input logic          xfer_abort
);

    p_nd_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_protect && !dsc_load) |=> ($stable(nd_lo) && $stable(nd_hi)));

    p_zero_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_active && chain_zero) |=> !chan_active);

    p_fetch_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    p_fetch_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> chan_active);

    p_chain_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && chain_zero) |=> !chan_active);

    p_fetch_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_low == '0));

    p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> (!chan_active && xfer_abort));

endmodule

bind dma_desc_loader dma_dl_checker #(.AW(AW), .AB(AB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .chan_active (chan_active),
    .fetch_req   (fetch_req),
    .fetch_low   (fetch_addr[AB-1:0]),
    .nd_lo       (regs_q[4]),
    .nd_hi       (regs_q[5]),
    .nd_protect  (nd_protect),
    .dsc_load    (dsc_load),
    .chain_zero  (chain_zero),
    .abort_hit   (abort_hit),
    .xfer_abort  (xfer_abort)
);

// File: tb/dma_desc_loader_tb_top.sv
`timescale 1ns/1ps
module dma_desc_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [2:0]  sw_wr_sel = '0;
    logic [31:0] sw_wr_data = '0;
    logic [2:0]  sw_rd_sel = '0;
    logic [31:0] sw_rd_data;
    logic        dsc_valid = 1'b0;
    logic [2:0]  dsc_idx = '0;
    logic [31:0] dsc_data = '0;
    logic        fetch_req;
    logic [31:0] fetch_addr, src_addr, dst_addr;
    logic [1:0]  src_type_cfg = 2'd2;
    logic [1:0]  dst_type_cfg = 2'd1;
    logic        rd_chk_valid = 1'b0;
    logic [1:0]  rd_chk_type = '0;
    logic        wr_chk_valid = 1'b0;
    logic [1:0]  wr_chk_type = '0;
    logic        chan_active, align_err, xfer_abort;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    dma_desc_loader dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        sw_rd_sel = sel;
        #1;
        v = sw_rd_data;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic dsc(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        dsc_valid = 1'b1; dsc_idx = idx; dsc_data = d;
        @(negedge clk);
        dsc_valid = 1'b0;
    endtask

    task automatic load_desc(input logic [31:0] ndl, input logic [31:0] ndh);
        dsc(3'd0, 32'h1122_3345);
        dsc(3'd1, 32'hAAAA_0001);
        dsc(3'd2, 32'h5566_7701);
        dsc(3'd3, 32'hBBBB_0002);
        dsc(3'd4, ndl);
        dsc(3'd5, ndh);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_fetch(input logic [31:0] a, input string tag);
        exp_q.push_back(a);
        tag_q.push_back(tag);
    endtask

    task automatic pulse_chk(input bit rdv, input bit wrv, input logic [1:0] ty);
        @(negedge clk);
        rd_chk_valid = rdv; wr_chk_valid = wrv;
        rd_chk_type = ty;   wr_chk_type = ty;
        @(negedge clk);
        rd_chk_valid = 1'b0; wr_chk_valid = 1'b0;
    endtask

    // Scoreboard monitor: every fetch must match the next expected address.
    always @(negedge clk) begin
        if (rst_n && fetch_req) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected fetch", fetch_addr, 32'hFFFF_FFFF);
            end else begin
                chk(tag_q.pop_front(), fetch_addr, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 8; s++) begin
            rd(3'(s), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 reset fetch_req", {31'b0, fetch_req}, 32'h0);
        chk("R1 reset active", {31'b0, chan_active}, 32'h0);

        // R4 start with zero pointer
        wr(3'd6, 32'h1);
        repeat (3) @(negedge clk);
        rd(3'd7, v); chk("R4 zero start status", v, 32'h0);
        rd(3'd6, v); chk("R3 start bit readback", v, 32'h1);
        wr(3'd6, 32'h0);

        // R3 unprotected write, then R5 launch
        wr(3'd4, 32'h0000_1000);
        rd(3'd4, v); chk("R3 write accepted", v, 32'h0000_1000);
        expect_fetch(32'h0000_1000, "R5 launch fetch");
        wr(3'd6, 32'h1);
        chk("R5 active after launch", {31'b0, chan_active}, 32'h1);
        wr(3'd4, 32'h0000_2000);
        rd(3'd4, v); chk("R3 write ignored while active", v, 32'h0000_1000);

        // R2 / R6 / R9 first descriptor
        expect_fetch(32'h0000_2000, "R6 chained fetch");
        load_desc(32'h0000_2000, 32'h0);
        rd(3'd0, v); chk("R2 src_lo", v, 32'h1122_3345);
        rd(3'd1, v); chk("R2 src_hi", v, 32'hAAAA_0001);
        rd(3'd2, v); chk("R2 dst_lo", v, 32'h5566_7701);
        rd(3'd3, v); chk("R2 dst_hi", v, 32'hBBBB_0002);
        rd(3'd4, v); chk("R2 nd_lo", v, 32'h0000_2000);
        chk("R9 src_addr", src_addr, 32'h1122_3345);
        chk("R9 dst_addr", dst_addr, 32'h5566_7701);

        // R7 misaligned pointer
        expect_fetch(32'h0000_3000, "R7 aligned fetch addr");
        load_desc(32'h0000_3007, 32'h0);
        chk("R7 align flag", {31'b0, align_err}, 32'h1);

        // R6 low half zero, high half nonzero: chain goes on
        expect_fetch(32'h0000_0000, "R6 high-only pointer fetch");
        load_desc(32'h0, 32'h1);
        rd(3'd5, v); chk("R2 nd_hi", v, 32'h1);
        chk("R6 still active", {31'b0, chan_active}, 32'h1);

        // R6 end of chain
        load_desc(32'h0, 32'h0);
        chk("R6 chain end inactive", {31'b0, chan_active}, 32'h0);

        // R3 start still set protects the pointer
        wr(3'd4, 32'h0000_4000);
        rd(3'd4, v); chk("R3 write ignored while start set", v, 32'h0);
        wr(3'd6, 32'h0);
        wr(3'd4, 32'h0000_4000);
        rd(3'd4, v); chk("R3 write after start clear", v, 32'h0000_4000);

        // R2 dword while idle is ignored
        dsc(3'd0, 32'hDEAD_BEEF);
        rd(3'd0, v); chk("R2 idle dword ignored", v, 32'h1122_3345);

        // R8 abort
        expect_fetch(32'h0000_4000, "R5 relaunch fetch");
        wr(3'd6, 32'h1);
        pulse_chk(1'b1, 1'b0, 2'd2);
        rd(3'd7, v); chk("R8 matching type no abort", v, 32'h1);
        pulse_chk(1'b0, 1'b1, 2'd3);
        rd(3'd7, v); chk("R8 mismatch abort status", v, 32'h4);

        // R8 / R7 flags cleared by next launch
        wr(3'd6, 32'h0);
        expect_fetch(32'h0000_4000, "R8 launch after abort");
        wr(3'd6, 32'h1);
        @(negedge clk);
        rd(3'd7, v); chk("R8 flags cleared on launch", v, 32'h1);

        repeat (3) @(negedge clk);
        chk("R5 all expected fetches seen", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule